// File: doc/BRIEF.md
# Tagged Many-to-One Stream Merger

This block gathers words from several independent producers onto one consumer stream. Every producer has a private input queue. A producer can write whenever its own queue has room, whatever the other producers or the consumer are doing. A fair arbiter picks among the queues that hold data and offers the head word of the chosen queue on a single output. The output word carries the index of the producer that wrote it, so the consumer can tell the words apart.

The output uses a valid/acknowledge handshake. Once a word is offered, it stays on the output until the consumer acknowledges it. Only the acknowledged word is taken out of its queue. Grants rotate round-robin, so a producer with data never waits behind more than the other N-1 producers.

Top module: `tagmerge`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0 and every bit of `src_ready` is 1.
- R2: Each producer queue holds `DEPTH` words. `src_ready[i]` drops only when queue i holds `DEPTH` words. A word presented on `src_valid[i]` while `src_ready[i]` is 0 is discarded and never appears on the output.
- R3: `out_word` is the producer index in the upper `ID_W` bits, followed by that producer's data in the lower `DATA_W` bits. `ID_W` is ceil(log2(`N_SRC`)), with a minimum of 1.
- R4: While `out_valid` is 1 and `out_ack` is 0, `out_valid` stays 1 and `out_word` does not change, even if other queues become non-empty. A word leaves its queue only on a clock edge where `out_valid` and `out_ack` are both 1.
- R5: After producer i is served, the next grant goes to the first non-empty queue found scanning cyclically from i+1. A producer with queued data is served within `N_SRC` grants.
- R6: Words from one producer appear on the output in the order that producer wrote them.
- R7: A word written into an empty merger is offered on the output in the cycle after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | N_SRC | Per-producer write strobe |
| src_data | input | N_SRC*DATA_W | Per-producer data, producer i in bits [i*DATA_W +: DATA_W] |
| src_ready | output | N_SRC | Per-producer queue has room |
| out_valid | output | 1 | A tagged word is offered |
| out_word | output | ID_W+DATA_W | {producer index, data} |
| out_ack | input | 1 | Consumer takes the offered word |

## Verification
The tests start with a single word into an idle block. This shows the one-cycle latency and the tag layout. Holding back the acknowledge then checks that the offered word stays put. A burst from one producer shows that words keep their order within a producer. Overfilling one queue shows that back-pressure is confined to that producer and that the excess word is dropped. Loading all queues at once shows the rotating grant order. A late arrival behind a held grant separates arbitration that is locked during a wait from arbitration that would re-decide each cycle.

// File: rtl/tagmerge_pkg.sv
// Shared helpers for the tagged merger.
package tagmerge_pkg;
    // Width of the producer tag: ceil(log2(n)), at least one bit.
    function automatic int id_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/tm_queue.sv
// Per-producer FIFO queue.
// Accepts a word when push is set and the queue is not full. Drops a
// word when pop is set and the queue is not empty. Head data comes
// straight from storage.
// Assumes DEPTH >= 1.
module tm_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nempty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign nempty  = (count != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && nempty;
    assign head    = mem[rd_ptr];

    // Write the accepted word into storage.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tm_rr_pick.sv
// Round-robin grant with hold.
// Scans the requests cyclically from a base index and grants the first
// one it finds. Once a grant has been offered without ack, the grant is
// locked until ack. On ack, the base moves to the index after the one
// served.
// Assumes a granted request stays set until it is acked.
module tm_rr_pick #(
    parameter int N = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [N-1:0]                            req,
    input  logic                                    ack,
    output logic                                    gnt_valid,
    output logic [tagmerge_pkg::id_width(N)-1:0]    gnt_idx
);
    localparam int IW = tagmerge_pkg::id_width(N);

    logic [IW-1:0] base, pick_idx, held_idx;
    logic          pick_any, held;

    // Find the first request at or after base, cyclically.
    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int t;
            t = int'(base) + k;
            if (t >= N) t = t - N;
            if (req[t]) begin
                pick_any = 1'b1;
                pick_idx = IW'(t);
            end
        end
    end

    assign gnt_valid = held || pick_any;
    assign gnt_idx   = held ? held_idx : pick_idx;

    // Lock an offered grant; rotate the base when it is acked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base     <= '0;
            held     <= 1'b0;
            held_idx <= '0;
        end else if (gnt_valid && ack) begin
            held <= 1'b0;
            base <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
        end else if (gnt_valid && !held) begin
            held     <= 1'b1;
            held_idx <= pick_idx;
        end
    end
endmodule

// File: rtl/tagmerge.sv
// Tagged many-to-one merger.
// Each producer writes into a private tm_queue. A tm_rr_pick selects one
// non-empty queue and offers its head word, tagged with the queue index,
// on out_word. The head is removed on the edge where out_valid and
// out_ack are both high.
// Assumes out_ack is only meaningful while out_valid is high.
module tagmerge #(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic [N_SRC-1:0]                                    src_valid,
    input  logic [N_SRC*DATA_W-1:0]                             src_data,
    output logic [N_SRC-1:0]                                    src_ready,
    output logic                                                out_valid,
    output logic [tagmerge_pkg::id_width(N_SRC)+DATA_W-1:0]     out_word,
    input  logic                                                out_ack
);
    localparam int ID_W = tagmerge_pkg::id_width(N_SRC);

    logic [DATA_W-1:0] heads [N_SRC];
    logic [N_SRC-1:0]  q_nempty, q_full, q_pop;
    logic [ID_W-1:0]   gnt_idx;
    logic              gnt_valid;

    // One queue per producer.
    for (genvar i = 0; i < N_SRC; i++) begin : g_q
        assign q_pop[i] = out_ack && gnt_valid && (gnt_idx == ID_W'(i));
        tm_queue #(.W(DATA_W), .DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (src_valid[i]),
            .push_data(src_data[i*DATA_W +: DATA_W]),
            .pop      (q_pop[i]),
            .head     (heads[i]),
            .nempty   (q_nempty[i]),
            .full     (q_full[i])
        );
    end

    assign src_ready = ~q_full;

    tm_rr_pick #(.N(N_SRC)) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (q_nempty),
        .ack      (out_ack),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    assign out_valid = gnt_valid;
    assign out_word  = {gnt_idx, heads[gnt_idx]};
endmodule

// File: rtl/tagmerge_chk.sv
// Property checker for tagmerge, bound to every instance.
// Observes the output handshake together with the queue occupancy flags
// and the grant index inside the top.
module tagmerge_chk #(
    parameter int N_SRC  = 4,
    parameter int DATA_W = 8
) (
    input  logic                                                clk,
    input  logic                                                rst_n,
    input  logic                                                out_valid,
    input  logic                                                out_ack,
    input  logic [tagmerge_pkg::id_width(N_SRC)+DATA_W-1:0]     out_word,
    input  logic [N_SRC-1:0]                                    q_nempty,
    input  logic [tagmerge_pkg::id_width(N_SRC)-1:0]            gnt_idx
);
    localparam int ID_W = tagmerge_pkg::id_width(N_SRC);

    // R1: with every queue empty, nothing is offered.
    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(|q_nempty) |-> !out_valid);

    // R3: the tag on the output names a queue that holds data.
    p_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> q_nempty[out_word[DATA_W +: ID_W]]);

    // R4: an unacknowledged word is held unchanged.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ack |=> out_valid && $stable(out_word));

    // R5: count the grants that pass over each waiting producer.
    for (genvar i = 0; i < N_SRC; i++) begin : g_fair
        logic [7:0] wait_cnt;
        always_ff @(posedge clk) begin
            if (!rst_n || !q_nempty[i]) wait_cnt <= '0;
            else if (out_valid && out_ack) begin
                if (gnt_idx == ID_W'(i)) wait_cnt <= '0;
                else if (wait_cnt != 8'hFF) wait_cnt <= wait_cnt + 1'b1;
            end
        end
        p_fair_r5: assert property (@(posedge clk) disable iff (!rst_n)
            wait_cnt < 8'(N_SRC));
    end
endmodule

bind tagmerge tagmerge_chk #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ack  (out_ack),
    .out_word (out_word),
    .q_nempty (q_nempty),
    .gnt_idx  (gnt_idx)
);

// File: tb/sim_tagmerge.sv
`timescale 1ns/1ps
// Directed bench for tagmerge: one task per scenario, with a reference
// model of the queue contents.
module sim_tagmerge;
    localparam int N = 4;
    localparam int DW = 8;
    localparam int DEPTH = 4;
    localparam int IW = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      src_valid = '0;
    logic [N*DW-1:0]   src_data = '0;
    logic [N-1:0]      src_ready;
    logic              out_valid;
    logic [IW+DW-1:0]  out_word;
    logic              out_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int mq [N][$];
    int last_id = N - 1;

    always #10 clk = ~clk;

    tagmerge #(.N_SRC(N), .DATA_W(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_data(src_data),
        .src_ready(src_ready), .out_valid(out_valid), .out_word(out_word),
        .out_ack(out_ack)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write to the producers in mask during one edge; model follows ready.
    task automatic push_m(input logic [N-1:0] m, input int base);
        @(negedge clk);
        for (int s = 0; s < N; s++) begin
            if (m[s]) begin
                src_valid[s] = 1'b1;
                src_data[s*DW +: DW] = DW'(base + s * 16);
                if (src_ready[s]) mq[s].push_back(base + s * 16);
            end
        end
        @(negedge clk);
        src_valid = '0;
    endtask

    function automatic int exp_next();
        for (int k = 1; k <= N; k++) begin
            int t;
            t = (last_id + k) % N;
            if (mq[t].size() != 0) return t;
        end
        return -1;
    endfunction

    // Check the offered word against producer id, then acknowledge it.
    task automatic pop_id(input int id, input string req);
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " word"}, 32'(out_word), 32'({IW'(id), DW'(mq[id][0])}));
        out_ack = 1'b1;
        @(negedge clk);
        out_ack = 1'b0;
        void'(mq[id].pop_front());
        last_id = id;
    endtask

    task automatic pop_rr(input string req);
        pop_id(exp_next(), req);
    endtask

    task automatic t_reset();
        chk("R1 valid", 32'(out_valid), 32'd0);
        chk("R1 ready", 32'(src_ready), 32'hF);
    endtask

    task automatic t_single();
        logic [IW+DW-1:0] w;
        push_m(4'b0100, 8'hA5 - 32);
        chk("R7 valid", 32'(out_valid), 32'd1);
        chk("R3 word", 32'(out_word), 32'({2'd2, 8'hA5}));
        w = out_word;
        repeat (3) @(negedge clk);
        chk("R4 held", 32'(out_word), 32'(w));
        pop_rr("R3 pop");
        chk("R4 removed", 32'(out_valid), 32'd0);
    endtask

    task automatic t_order();
        push_m(4'b0010, 1);
        push_m(4'b0010, 2);
        push_m(4'b0010, 3);
        for (int i = 0; i < 3; i++) pop_rr("R6 order");
        chk("R6 empty", 32'(out_valid), 32'd0);
    endtask

    task automatic t_full();
        for (int i = 0; i < DEPTH; i++) push_m(4'b0001, 40 + i);
        chk("R2 ready full", 32'(src_ready), 32'hE);
        push_m(4'b0001, 99);
        chk("R2 ready still", 32'(src_ready), 32'hE);
        for (int i = 0; i < DEPTH; i++) pop_rr("R2 drain");
        chk("R2 dropped", 32'(out_valid), 32'd0);
        chk("R2 ready back", 32'(src_ready), 32'hF);
    endtask

    task automatic t_rotate();
        push_m(4'b1111, 1);
        push_m(4'b1111, 2);
        for (int i = 0; i < 2 * N; i++) pop_rr("R5 rotate");
        chk("R5 empty", 32'(out_valid), 32'd0);
    endtask

    task automatic t_late();
        int id;
        logic [IW+DW-1:0] w;
        push_m(4'b1000, 5);
        push_m(4'b1000, 6);
        id = exp_next();
        w = out_word;
        push_m(4'b0111, 7);
        chk("R4 locked", 32'(out_word), 32'(w));
        pop_id(id, "R4 locked pop");
        while (exp_next() >= 0) pop_rr("R5 late");
        chk("R5 late empty", 32'(out_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_order();
        t_full();
        t_rotate();
        t_late();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule